// File: doc/BRIEF.md
# Packed Lane Shift-Left-Insert Unit

This block is a vector datapath stage. It splits a wide source vector and a wide destination vector into equal lanes of 8, 16, 32 or 64 bits. Each source lane is shifted left by an immediate amount. The shifted value is then merged into the matching destination lane. Destination bits below the shift point keep their old values, and source bits pushed past the top of a lane are dropped.

A single packed 7-bit immediate sets both the lane width and the shift. It is made of a 4-bit size selector `sizeSel` and a 3-bit low field `shiftLow`. The highest set bit of the selector picks the lane width. The shift is the 7-bit value `{sizeSel, shiftLow}` minus that width. A selector of zero is a reserved encoding and is flagged as illegal.

There is no predication, so every lane is written on every operation. The result is registered, and it appears one cycle after the input strobe.

Top module: `lane_shift_insert`

## Requirements
- R1: `sizeSel` selects the lane width from its highest set bit: 4'b0001 gives 8 bits, 4'b001x gives 16, 4'b01xx gives 32 and 4'b1xxx gives 64.
- R2: The shift amount is the unsigned value of `{sizeSel, shiftLow}` minus the lane width. It always lies between 0 and the lane width minus 1.
- R3: Each lane result is `(dst AND NOT mask) OR (src << shift)`, where `mask` is all ones shifted left by the shift amount. Lane 0 sits in the least significant bits.
- R4: Source bits shifted past the top of a lane are discarded and never reach the next lane.
- R5: Destination bits below the shift point keep their input values. For example, bit 0 of the output equals bit 0 of the destination whenever the shift is non-zero.
- R6: Every lane of the vector is updated by each operation.
- R7: With a shift of zero, every output lane equals the source lane.
- R8: `sizeSel` of 4'b0000 is illegal. In that case `outIllegal` is raised together with `outValid`, and `outVec` equals the destination input unchanged.
- R9: `outValid` follows `inValid` with exactly one cycle of latency, and `outVec` carries the result of the input sampled in that cycle.
- R10: A synchronous active-high `rst` clears `outValid` and `outIllegal`.
- R11: In a cycle without `inValid`, `outVec` holds its last value and `outIllegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| sizeSel | input | 4 | Lane-size selector, the upper part of the immediate |
| shiftLow | input | 3 | Low three bits of the immediate |
| srcVec | input | VEC_W | Source vector |
| dstVec | input | VEC_W | Current destination vector |
| outValid | output | 1 | Result strobe |
| outIllegal | output | 1 | Reserved-encoding flag |
| outVec | output | VEC_W | Merged result vector |

## Verification
A sweep covers all fifteen legal selectors with all eight low-field values, each with random operands. This separates the 16/32/64-bit selector patterns that share a leading bit, and it reaches every shift from 0 to the width minus 1.

Directed patterns isolate single behaviours:
- An all-ones source at the largest shift would show any bit leaking across a lane boundary.
- An all-ones destination under a zero source exposes a mask that clears too many or too few low bits.
- Zero-shift cases show whether the source passes through whole.

The reserved selector is driven with a random destination to confirm the untouched pass-through. Idle cycles and a mid-run reset check the hold and clear behaviour.

// File: rtl/lsi_pkg.sv
package lsi_pkg;
  localparam int NumSizes = 4;
  localparam int ShiftW = 6;

  typedef struct packed {
    logic                load;
    logic [NumSizes-1:0] laneSel;   // one-hot: bit k picks lanes of 8<<k bits
    logic [ShiftW-1:0]   shiftAmt;
  } lsi_ctrl_t;
endpackage

// File: rtl/lsi_control.sv
module lsi_control
  import lsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [3:0] sizeSel,
  input  logic [2:0] shiftLow,
  output lsi_ctrl_t  ctrl,
  output logic       outValid,
  output logic       outIllegal
);
  logic illegal;

  always_comb begin
    ctrl.load     = inValid;
    ctrl.laneSel  = '0;
    ctrl.shiftAmt = '0;
    illegal       = 1'b0;
    if (sizeSel[3]) begin
      ctrl.laneSel  = 4'b1000;
      ctrl.shiftAmt = {sizeSel[2:0], shiftLow};
    end else if (sizeSel[2]) begin
      ctrl.laneSel  = 4'b0100;
      ctrl.shiftAmt = {1'b0, sizeSel[1:0], shiftLow};
    end else if (sizeSel[1]) begin
      ctrl.laneSel  = 4'b0010;
      ctrl.shiftAmt = {2'b00, sizeSel[0], shiftLow};
    end else if (sizeSel[0]) begin
      ctrl.laneSel  = 4'b0001;
      ctrl.shiftAmt = {3'b000, shiftLow};
    end else begin
      illegal = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      outValid   <= inValid;
      outIllegal <= inValid & illegal;
    end
  end

  assert_illegal_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
    outIllegal |-> outValid);

  assert_idle_no_flag_R11: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> !outIllegal);
endmodule

// File: rtl/lsi_datapath.sv
module lsi_datapath
  import lsi_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  lsi_ctrl_t        ctrl,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstVec,
  output logic [VEC_W-1:0] outVec
);
  logic [NumSizes-1:0][VEC_W-1:0] sizeRes;
  logic [VEC_W-1:0]               merged;

  for (genvar k = 0; k < NumSizes; k++) begin : g_size
    localparam int LaneW    = 8 << k;
    localparam int NumLanes = VEC_W / LaneW;
    localparam int ShW      = 3 + k;
    logic [ShW-1:0] sh;
    assign sh = ctrl.shiftAmt[ShW-1:0];
    for (genvar l = 0; l < NumLanes; l++) begin : g_lane
      logic [LaneW-1:0] srcLane, dstLane, keepMask;
      assign srcLane  = srcVec[l*LaneW +: LaneW];
      assign dstLane  = dstVec[l*LaneW +: LaneW];
      assign keepMask = {LaneW{1'b1}} << sh;
      assign sizeRes[k][l*LaneW +: LaneW] = (dstLane & ~keepMask) | (srcLane << sh);
    end
  end

  always_comb begin
    merged = dstVec;
    for (int k = 0; k < NumSizes; k++)
      if (ctrl.laneSel[k]) merged = sizeRes[k];
  end

  always_ff @(posedge clk) begin
    if (ctrl.load) outVec <= merged;
  end

  assert_one_size_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl.laneSel));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> $stable(outVec));
endmodule

// File: rtl/lane_shift_insert.sv
module lane_shift_insert #(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [3:0]       sizeSel,
  input  logic [2:0]       shiftLow,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstVec,
  output logic             outValid,
  output logic             outIllegal,
  output logic [VEC_W-1:0] outVec
);
  lsi_pkg::lsi_ctrl_t ctrl;

  lsi_control u_control (
    .clk(clk), .rst(rst), .inValid(inValid), .sizeSel(sizeSel),
    .shiftLow(shiftLow), .ctrl(ctrl), .outValid(outValid), .outIllegal(outIllegal)
  );

  lsi_datapath #(.VEC_W(VEC_W)) u_datapath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .srcVec(srcVec), .dstVec(dstVec), .outVec(outVec)
  );

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (outValid == $past(inValid)));

  assert_illegal_passthru_R8: assert property (@(posedge clk) disable iff (rst)
    outIllegal |-> (outVec == $past(dstVec)));

  // Shift is zero exactly when sizeSel is a power of two and shiftLow is zero.
  assert_zero_shift_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outIllegal && ($past(sizeSel) & ($past(sizeSel) - 4'd1)) == 4'd0
     && $past(shiftLow) == 3'd0) |-> (outVec == $past(srcVec)));

  assert_low_bit_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outIllegal && !((($past(sizeSel) & ($past(sizeSel) - 4'd1)) == 4'd0)
     && $past(shiftLow) == 3'd0)) |-> (outVec[0] == $past(dstVec[0])));
endmodule

// File: tb/lane_shift_insert_tb.sv
`timescale 1ns/1ps
module lane_shift_insert_tb;
  localparam int VEC_W = 256;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [3:0]       sizeSel = '0;
  logic [2:0]       shiftLow = '0;
  logic [VEC_W-1:0] srcVec = '0;
  logic [VEC_W-1:0] dstVec = '0;
  logic             outValid, outIllegal;
  logic [VEC_W-1:0] outVec;

  int checks = 0;
  int errors = 0;
  logic [VEC_W-1:0] heldVec;

  always #4 clk = ~clk;

  lane_shift_insert #(.VEC_W(VEC_W)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .sizeSel(sizeSel), .shiftLow(shiftLow),
    .srcVec(srcVec), .dstVec(dstVec), .outValid(outValid), .outIllegal(outIllegal),
    .outVec(outVec)
  );

  function automatic int widthOf(input logic [3:0] s);
    if (s[3]) return 64;
    if (s[2]) return 32;
    if (s[1]) return 16;
    if (s[0]) return 8;
    return 0;
  endfunction

  function automatic logic [VEC_W-1:0] model(input logic [3:0] s, input logic [2:0] lo,
                                             input logic [VEC_W-1:0] src,
                                             input logic [VEC_W-1:0] dst);
    int w;
    int sh;
    logic [VEC_W-1:0] r;
    w = widthOf(s);
    if (w == 0) return dst;
    sh = int'({s, lo}) - w;
    for (int i = 0; i < VEC_W; i++) begin
      int pos;
      pos = i % w;
      r[i] = (pos < sh) ? dst[i] : src[i - sh];
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] randVec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < VEC_W / 32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic check(input string tag, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, check the registered result one cycle later.
  task automatic op(input string tag, input logic [3:0] s, input logic [2:0] lo,
                    input logic [VEC_W-1:0] src, input logic [VEC_W-1:0] dst);
    logic [VEC_W-1:0] exp;
    exp = model(s, lo, src, dst);
    inValid = 1'b1; sizeSel = s; shiftLow = lo; srcVec = src; dstVec = dst;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " valid R9"}, VEC_W'(outValid), VEC_W'(1));
    check({tag, " illegal flag R8"}, VEC_W'(outIllegal), VEC_W'(s == 4'd0));
    check(tag, outVec, exp);
    heldVec = exp;
  endtask

  task automatic idle();
    srcVec = randVec(); dstVec = randVec(); sizeSel = 4'($urandom()); shiftLow = 3'($urandom());
    @(negedge clk);
    check("idle valid R9", VEC_W'(outValid), VEC_W'(0));
    check("idle flag R11", VEC_W'(outIllegal), VEC_W'(0));
    check("idle hold R11", outVec, heldVec);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    check("reset valid R10", VEC_W'(outValid), VEC_W'(0));
    check("reset flag R10", VEC_W'(outIllegal), VEC_W'(0));
    rst = 1'b0;
    inValid = 1'b0;
    @(negedge clk);

    // R1: selectors sharing a leading bit decode to the same width
    op("R1 sel0011", 4'b0011, 3'd5, randVec(), randVec());
    op("R1 sel0111", 4'b0111, 3'd2, randVec(), randVec());
    op("R1 sel1101", 4'b1101, 3'd7, randVec(), randVec());
    op("R1 sel0001", 4'b0001, 3'd3, randVec(), randVec());
    // R2: largest shift per width
    op("R2 max8", 4'b0001, 3'd7, randVec(), randVec());
    op("R2 max64", 4'b1111, 3'd7, randVec(), randVec());
    // R4: all-ones source at top shift must not spill over lanes
    op("R4 spill8", 4'b0001, 3'd7, '1, '0);
    op("R4 spill16", 4'b0011, 3'd7, '1, '0);
    op("R4 spill32", 4'b0111, 3'd7, '1, '0);
    op("R4 spill64", 4'b1111, 3'd7, '1, '0);
    // R5: zero source into all-ones destination shows kept low bits
    op("R5 keep16", 4'b0010, 3'd4, '0, '1);
    op("R5 keep64", 4'b1010, 3'd1, '0, '1);
    // R6: every lane written
    op("R6 all lanes", 4'b0100, 3'd1, '1, '0);
    // R7: zero shift copies source
    op("R7 zero8", 4'b0001, 3'd0, randVec(), randVec());
    op("R7 zero64", 4'b1000, 3'd0, randVec(), randVec());
    // R8: reserved selector
    op("R8 reserved", 4'b0000, 3'd6, randVec(), randVec());
    idle();
    op("R8 reserved b", 4'b0000, 3'd0, randVec(), randVec());
    idle();
    idle();

    // R3: full sweep of legal encodings, back-to-back
    for (int s = 1; s < 16; s++)
      for (int lo = 0; lo < 8; lo++)
        for (int rep = 0; rep < 3; rep++)
          op("R3 sweep", 4'(s), 3'(lo), randVec(), randVec());
    idle();

    // R10: reset in mid-stream clears the strobes
    inValid = 1'b1; sizeSel = 4'b0000; rst = 1'b1;
    @(negedge clk);
    check("midreset valid R10", VEC_W'(outValid), VEC_W'(0));
    check("midreset flag R10", VEC_W'(outIllegal), VEC_W'(0));
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);
    op("R9 after reset", 4'b0110, 3'd3, randVec(), randVec());

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule